// File: doc/BRIEF.md
# Operand Word Fetch Sequencer

This block brings an operand in from memory, one word at a time, once the instruction word has already been decoded. A two-bit format code sets how many consecutive words make up the operand and which destination register each word fills. The possible words are an exponent word, a high mantissa word and a low mantissa word. For every word the block runs a read handshake on the memory port: it puts out the address with a request, waits for the address acknowledge, takes the data on read-restart, then raises a release and waits for its acknowledge. After each word it steps its address register by one.

An instruction that makes no memory reference does not use the fetch at all. The block then reports completion on the next cycle, and the accumulator registers keep their current contents as the operand. Completion is marked by a one-cycle pulse.

Top module: `opf_operand_fetch`

## Requirements
- R1: After reset, and whenever the block is idle, mem_req_o, release_o, busy_o and done_o are 0. exp_o, mant_o and addr_o are 0 after reset, and a reset in the middle of a fetch returns the block to this state.
- R2: The format code fmt_i (bit 1 = exponent word present, bit 0 = low mantissa word present) sets the order of fetched words. 2'b11 gives exponent, high, low. 2'b10 gives exponent, high. 2'b01 gives high, low. 2'b00 gives high only.
- R3: The cycle after a start is accepted, mem_req_o rises with mem_addr_o = the address register. Request and address hold until bus_ack_i is sampled, and mem_addr_o is 0 while there is no request. After rd_restart_i is sampled, release_o stays high until rel_ack_i is sampled. mem_req_o and release_o are never high together.
- R4: Data on rd_data_i is captured in the cycle rd_restart_i is sampled. An exponent word goes to exp_o, a high word to mant_o[2*WORD_W-1:WORD_W] and a low word to mant_o[WORD_W-1:0].
- R5: The address register loads addr_i when a fetch starts and increments by 1 after each word's release acknowledge. It wraps modulo 2^ADDR_W (17'h1FFFF + 1 = 0).
- R6: When start_i is accepted with no_mem_i = 1, done_o pulses in the next cycle and no request is made. exp_o, mant_o and addr_o are left unchanged.
- R7: done_o is high for exactly one cycle: the cycle after rel_ack_i is sampled for the last word. busy_o is high from the cycle after acceptance through the done cycle.
- R8: start_i while busy_o is 1 is ignored, and the running fetch proceeds unchanged.
- R9: Destination registers for words the format does not fetch keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin operand fetch (accepted when idle) |
| fmt_i | input | 2 | Format code: bit 1 exponent word, bit 0 low word |
| no_mem_i | input | 1 | Instruction makes no memory reference |
| addr_i | input | ADDR_W | Address of the first operand word |
| mem_req_o | output | 1 | Read request, address valid |
| mem_addr_o | output | ADDR_W | Address to memory, 0 when no request |
| bus_ack_i | input | 1 | Address acknowledge |
| rd_restart_i | input | 1 | Read data valid |
| rd_data_i | input | WORD_W | Read data word |
| release_o | output | 1 | Release / data acknowledge |
| rel_ack_i | input | 1 | Release acknowledge |
| exp_o | output | WORD_W | Exponent register |
| mant_o | output | 2*WORD_W | Mantissa register, high word on top |
| addr_o | output | ADDR_W | Address register |
| busy_o | output | 1 | Fetch in progress (through done cycle) |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The fetch is tried with all four format codes, so that the one-, two- and three-word sequences are each seen. Each sequence is checked for its word order, the address of every word and which registers are left untouched. Start addresses at 17'h1FFFE and 17'h1FFFF show whether the address wraps. A no-memory start with a three-word format must give done_o with no request, which separates a correct skip from an ignored flag. A second start inside a running fetch and a reset in the middle of a request show whether the sequencer holds its own sequence and returns cleanly to idle.

// File: rtl/opf_pkg.sv
package opf_pkg;
  typedef enum logic [1:0] {SLOT_EXP = 2'd0, SLOT_HI = 2'd1, SLOT_LO = 2'd2} slot_e;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0, ST_REQ = 3'd1, ST_WAITRD = 3'd2, ST_REL = 3'd3, ST_DONE = 3'd4
  } state_e;
  localparam int unsigned FMT_EXP_BIT = 1;
  localparam int unsigned FMT_LO_BIT  = 0;
  localparam int unsigned MAX_WORDS   = 3;
endpackage

// File: rtl/opf_word_plan.sv
module opf_word_plan
  import opf_pkg::*;
#(
  parameter int unsigned CNT_W = 2
) (
  input  logic [1:0]       fmt_i,
  input  slot_e            cur_slot_i,
  output logic [CNT_W-1:0] word_cnt_o,
  output slot_e            first_slot_o,
  output slot_e            next_slot_o
);
  always_comb begin
    word_cnt_o = CNT_W'(1) + CNT_W'(fmt_i[FMT_EXP_BIT]) + CNT_W'(fmt_i[FMT_LO_BIT]);
    first_slot_o = fmt_i[FMT_EXP_BIT] ? SLOT_EXP : SLOT_HI;
    unique case (cur_slot_i)
      SLOT_EXP: next_slot_o = SLOT_HI;
      SLOT_HI:  next_slot_o = SLOT_LO;
      default:  next_slot_o = SLOT_LO;
    endcase
  end
endmodule

// File: rtl/opf_addr_reg.sv
module opf_addr_reg #(
  parameter int unsigned ADDR_W = 17
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_val_i,
  input  logic              inc_i,
  output logic [ADDR_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= load_val_i;
    else if (inc_i)  q_o <= q_o + ADDR_W'(1);  // wraps modulo 2^ADDR_W
  end
endmodule

// File: rtl/opf_dest_regs.sv
module opf_dest_regs
  import opf_pkg::*;
#(
  parameter int unsigned WORD_W = 18
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  slot_e               slot_i,
  input  logic [WORD_W-1:0]   data_i,
  output logic [WORD_W-1:0]   exp_o,
  output logic [2*WORD_W-1:0] mant_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         exp_o <= '0;
    else if (we_i && slot_i == SLOT_EXP) exp_o <= data_i;
  end

  // half 1 = high mantissa word, half 0 = low mantissa word
  for (genvar g = 0; g < 2; g++) begin : g_half
    localparam slot_e HALF_SLOT = (g == 1) ? SLOT_HI : SLOT_LO;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          mant_o[g*WORD_W +: WORD_W] <= '0;
      else if (we_i && slot_i == HALF_SLOT) mant_o[g*WORD_W +: WORD_W] <= data_i;
    end
  end
endmodule

// File: rtl/opf_hs_fsm.sv
module opf_hs_fsm
  import opf_pkg::*;
#(
  parameter int unsigned CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             no_mem_i,
  input  logic [CNT_W-1:0] cnt_load_i,
  input  logic             bus_ack_i,
  input  logic             rd_restart_i,
  input  logic             rel_ack_i,
  output logic             accept_o,
  output logic             fetch_start_o,
  output logic             capture_o,
  output logic             word_done_o,
  output logic             req_o,
  output logic             rel_o,
  output logic             busy_o,
  output logic             done_o
);
  state_e           state_q, state_d;
  logic [CNT_W-1:0] cnt_q;
  logic             last_word;

  assign last_word     = (cnt_q == CNT_W'(1));
  assign accept_o      = (state_q == ST_IDLE) && start_i;
  assign fetch_start_o = accept_o && !no_mem_i;
  assign capture_o     = (state_q == ST_WAITRD) && rd_restart_i;
  assign word_done_o   = (state_q == ST_REL) && rel_ack_i;
  assign req_o         = (state_q == ST_REQ);
  assign rel_o         = (state_q == ST_REL);
  assign busy_o        = (state_q != ST_IDLE);
  assign done_o        = (state_q == ST_DONE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start_i) state_d = no_mem_i ? ST_DONE : ST_REQ;
      ST_REQ:    if (bus_ack_i) state_d = ST_WAITRD;
      ST_WAITRD: if (rd_restart_i) state_d = ST_REL;
      ST_REL:    if (rel_ack_i) state_d = last_word ? ST_DONE : ST_REQ;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (fetch_start_o)    cnt_q <= cnt_load_i;
      else if (word_done_o) cnt_q <= cnt_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/opf_operand_fetch.sv
module opf_operand_fetch
  import opf_pkg::*;
#(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned WORD_W = 18
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [1:0]          fmt_i,
  input  logic                no_mem_i,
  input  logic [ADDR_W-1:0]   addr_i,
  output logic                mem_req_o,
  output logic [ADDR_W-1:0]   mem_addr_o,
  input  logic                bus_ack_i,
  input  logic                rd_restart_i,
  input  logic [WORD_W-1:0]   rd_data_i,
  output logic                release_o,
  input  logic                rel_ack_i,
  output logic [WORD_W-1:0]   exp_o,
  output logic [2*WORD_W-1:0] mant_o,
  output logic [ADDR_W-1:0]   addr_o,
  output logic                busy_o,
  output logic                done_o
);
  localparam int unsigned CNT_W = $clog2(MAX_WORDS + 1);

  logic             accept, fetch_start, capture, word_done;
  logic [CNT_W-1:0] word_cnt;
  slot_e            slot_q, first_slot, next_slot;

  opf_word_plan #(.CNT_W(CNT_W)) u_plan (
    .fmt_i        (fmt_i),
    .cur_slot_i   (slot_q),
    .word_cnt_o   (word_cnt),
    .first_slot_o (first_slot),
    .next_slot_o  (next_slot)
  );

  opf_hs_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (start_i),
    .no_mem_i      (no_mem_i),
    .cnt_load_i    (word_cnt),
    .bus_ack_i     (bus_ack_i),
    .rd_restart_i  (rd_restart_i),
    .rel_ack_i     (rel_ack_i),
    .accept_o      (accept),
    .fetch_start_o (fetch_start),
    .capture_o     (capture),
    .word_done_o   (word_done),
    .req_o         (mem_req_o),
    .rel_o         (release_o),
    .busy_o        (busy_o),
    .done_o        (done_o)
  );

  // slot tracks the destination of the word in flight
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          slot_q <= SLOT_HI;
    else if (fetch_start) slot_q <= first_slot;
    else if (word_done)   slot_q <= next_slot;
  end

  opf_addr_reg #(.ADDR_W(ADDR_W)) u_addr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (fetch_start),
    .load_val_i (addr_i),
    .inc_i      (word_done),
    .q_o        (addr_o)
  );

  opf_dest_regs #(.WORD_W(WORD_W)) u_dest (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (capture),
    .slot_i (slot_q),
    .data_i (rd_data_i),
    .exp_o  (exp_o),
    .mant_o (mant_o)
  );

  assign mem_addr_o = mem_req_o ? addr_o : '0;

  logic unused_accept;
  assign unused_accept = accept;
endmodule

// File: rtl/opf_operand_fetch_chk.sv
module opf_operand_fetch_chk #(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned WORD_W = 18
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                start_i,
  input logic [1:0]          fmt_i,
  input logic                no_mem_i,
  input logic [ADDR_W-1:0]   addr_i,
  input logic                mem_req_o,
  input logic [ADDR_W-1:0]   mem_addr_o,
  input logic                bus_ack_i,
  input logic                rd_restart_i,
  input logic [WORD_W-1:0]   rd_data_i,
  input logic                release_o,
  input logic                rel_ack_i,
  input logic [WORD_W-1:0]   exp_o,
  input logic [2*WORD_W-1:0] mant_o,
  input logic [ADDR_W-1:0]   addr_o,
  input logic                busy_o,
  input logic                done_o
);
  localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o && !release_o && !done_o);

  p_req_rel_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_req_o && release_o));

  p_req_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !bus_ack_i |=> mem_req_o && $stable(mem_addr_o));

  p_rel_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_o && !rel_ack_i |=> release_o);

  p_addr_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_o && rel_ack_i |=> addr_o == $past(addr_o) + ONE);

  p_skip_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && no_mem_i && !busy_o |=> done_o && !mem_req_o);

  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_start_ignored_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !done_o && start_i && mem_req_o && !bus_ack_i |=> mem_req_o);
endmodule

bind opf_operand_fetch opf_operand_fetch_chk #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_chk (.*);

// File: tb/opf_operand_fetch_test.sv
`timescale 1ns/1ps
module opf_operand_fetch_test;
  localparam int unsigned AW = 17;
  localparam int unsigned WW = 18;
  localparam int unsigned NV = 8;
  // {no_mem, fmt[1:0], addr}
  localparam logic [19:0] VEC [NV] = '{
    {1'b0, 2'b11, 17'h00100}, {1'b0, 2'b10, 17'h00200},
    {1'b0, 2'b01, 17'h00300}, {1'b0, 2'b00, 17'h00400},
    {1'b1, 2'b11, 17'h00500}, {1'b0, 2'b11, 17'h1FFFE},
    {1'b0, 2'b00, 17'h1FFFF}, {1'b0, 2'b01, 17'h0ABCD}
  };

  logic clk = 0, rst_n = 0;
  logic start = 0, no_mem = 0, bus_ack = 0, rd_restart = 0, rel_ack = 0;
  logic [1:0] fmt = 0;
  logic [AW-1:0] addr_in = 0;
  logic [WW-1:0] rd_data = 0;
  logic mem_req, release_s, busy, done;
  logic [AW-1:0] mem_addr, addr_reg;
  logic [WW-1:0] exp_r;
  logic [2*WW-1:0] mant_r;

  int n_chk = 0, n_bad = 0;
  logic [WW-1:0] m_exp = 0, m_hi = 0, m_lo = 0;
  logic [AW-1:0] m_addr = 0;

  always #2.5 clk = ~clk;

  opf_operand_fetch uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .fmt_i(fmt), .no_mem_i(no_mem),
    .addr_i(addr_in), .mem_req_o(mem_req), .mem_addr_o(mem_addr), .bus_ack_i(bus_ack),
    .rd_restart_i(rd_restart), .rd_data_i(rd_data), .release_o(release_s),
    .rel_ack_i(rel_ack), .exp_o(exp_r), .mant_o(mant_r), .addr_o(addr_reg),
    .busy_o(busy), .done_o(done)
  );

  function automatic logic [WW-1:0] mem_word(input logic [AW-1:0] a);
    return {a, 1'b0} ^ 18'h15A3C;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_regs(input string tag);
    chk({tag, " exp_o"}, 64'(exp_r), 64'(m_exp));
    chk({tag, " mant_o"}, 64'(mant_r), 64'({m_hi, m_lo}));
    chk({tag, " addr_o"}, 64'(addr_reg), 64'(m_addr));
  endtask

  // one operand fetch, memory side driven by the bench at negedges
  task automatic run_op(input logic nm, input logic [1:0] f, input logic [AW-1:0] a,
                        input bit inject);
    int nw;
    logic [1:0] slots [3];
    logic [AW-1:0] wa;
    nw = 0;
    if (f[1]) begin slots[nw] = 2'd0; nw++; end
    slots[nw] = 2'd1; nw++;
    if (f[0]) begin slots[nw] = 2'd2; nw++; end
    @(negedge clk);
    start = 1; no_mem = nm; fmt = f; addr_in = a;
    @(negedge clk);
    start = 0;
    if (nm) begin
      chk("R6 done after skip", 64'(done), 64'd1);
      chk("R6 no request on skip", 64'(mem_req), 64'd0);
      @(negedge clk);
      chk("R7 done single pulse", 64'(done), 64'd0);
      check_regs("R6 skip unchanged");
      return;
    end
    wa = a;
    for (int k = 0; k < nw; k++) begin
      chk("R3 request up", 64'(mem_req), 64'd1);
      chk("R5 word address", 64'(mem_addr), 64'(wa));
      chk("R3 no release with request", 64'(release_s), 64'd0);
      chk("R7 busy", 64'(busy), 64'd1);
      bus_ack = 1;
      @(negedge clk);
      bus_ack = 0;
      chk("R3 request removed", 64'(mem_req), 64'd0);
      chk("R3 address removed", 64'(mem_addr), 64'd0);
      if (inject && k == 0) begin
        start = 1; no_mem = 1; fmt = ~f;
        @(negedge clk);
        start = 0;
        chk("R8 start ignored no done", 64'(done), 64'd0);
        chk("R8 start ignored no request", 64'(mem_req), 64'd0);
      end
      rd_restart = 1; rd_data = mem_word(wa);
      @(negedge clk);
      rd_restart = 0; rd_data = '0;
      chk("R3 release up", 64'(release_s), 64'd1);
      case (slots[k])
        2'd0: m_exp = mem_word(wa);
        2'd1: m_hi  = mem_word(wa);
        default: m_lo = mem_word(wa);
      endcase
      chk("R2 R4 R9 exp_o", 64'(exp_r), 64'(m_exp));
      chk("R2 R4 R9 mant_o", 64'(mant_r), 64'({m_hi, m_lo}));
      @(negedge clk);
      chk("R3 release held", 64'(release_s), 64'd1);
      rel_ack = 1;
      @(negedge clk);
      rel_ack = 0;
      chk("R3 release dropped", 64'(release_s), 64'd0);
      wa = wa + AW'(1);
      chk("R5 address step", 64'(addr_reg), 64'(wa));
      if (k == nw - 1) chk("R7 done after last word", 64'(done), 64'd1);
      else             chk("R7 no early done", 64'(done), 64'd0);
    end
    m_addr = wa;
    @(negedge clk);
    chk("R7 done single pulse", 64'(done), 64'd0);
    chk("R1 idle busy", 64'(busy), 64'd0);
    check_regs("R2 R9 final");
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset req", 64'(mem_req), 64'd0);
    chk("R1 reset busy", 64'(busy), 64'd0);
    chk("R1 reset done", 64'(done), 64'd0);
    check_regs("R1 reset");
    rst_n = 1;
    @(negedge clk);
    chk("R1 idle release", 64'(release_s), 64'd0);

    for (int i = 0; i < NV; i++)
      run_op(VEC[i][19], VEC[i][18:17], VEC[i][16:0], 1'b0);

    // R8: second start during a running fetch
    run_op(1'b0, 2'b10, 17'h01234, 1'b1);

    // R1: reset in the middle of a request
    @(negedge clk);
    start = 1; no_mem = 0; fmt = 2'b11; addr_in = 17'h00777;
    @(negedge clk);
    start = 0;
    chk("R1 pre-reset request", 64'(mem_req), 64'd1);
    rst_n = 0;
    @(negedge clk);
    m_exp = 0; m_hi = 0; m_lo = 0; m_addr = 0;
    chk("R1 mid reset req", 64'(mem_req), 64'd0);
    chk("R1 mid reset busy", 64'(busy), 64'd0);
    check_regs("R1 mid reset");
    rst_n = 1;
    run_op(1'b0, 2'b01, 17'h00040, 1'b0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule